// File: doc/BRIEF.md
# Edge-Capture GPIO Port

A parallel input/output port of up to 32 pins, reached over a simple word-addressed register bus with separate read and write strobes. Each pin can be driven as an output from a local output register or sampled as an input. Sampling goes through a two-flop synchroniser so that asynchronous pad signals can be used safely. The port drives output-enable and output-value vectors toward external tri-state pads. It also raises a single interrupt line toward a processor.

The interrupt trigger type is fixed when the block is built. It is one of rising edge, falling edge, either edge, or level high. In the three edge modes, each detected event sets a sticky per-pin capture bit. Software clears capture bits by writing ones to them. The interrupt is the OR of the capture bits that are enabled by the per-pin mask. In level-high mode no capture takes place, and the interrupt comes straight from the masked live pin view.

Top module: `pio_edge_port`

## Requirements
- R1: The bus address is a 2-bit word index: 0 selects pin data, 1 selects direction, 2 selects interrupt mask, and 3 selects edge capture, at byte offsets 0x0, 0x4, 0x8 and 0xC. `bus_rdata` is combinational and is zero while `bus_rd` is low. Register bits at or above `NUM_PINS` read as zero.
- R2: Direction bit 1 makes the pin an output and bit 0 makes it an input. `pad_oe` equals the direction register, and `pad_out` equals the output register.
- R3: Reading the data word returns the output register bit for output pins and the synchronised pad level for input pins. Writing the data word updates only the output register.
- R4: A pad change passes through two synchroniser flops and one edge-compare flop. The resulting capture bit is visible after the third rising clock edge after the change, and not after the second.
- R5: In rising mode (TRIG=0), a capture bit is set on each 0-to-1 transition of its synchronised pin.
- R6: In falling mode (TRIG=1), a capture bit is set on each 1-to-0 transition.
- R7: In both-edges mode (TRIG=2), a capture bit is set on any transition.
- R8: A write to the capture word clears each capture bit written as 1. Bits written as 0 are unchanged, and set bits hold until cleared.
- R9: If an edge is detected in the same cycle that a write clears that capture bit, the bit stays set.
- R10: In edge modes, `irq` is high exactly when the AND of the capture word and the mask word is nonzero.
- R11: In level mode (TRIG=3), `irq` is high exactly when the AND of the data read view and the mask is nonzero, and the capture word always reads zero.
- R12: Reset clears the direction, output, mask and capture registers, leaving `irq` low and `pad_oe` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Word index of register |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data |
| pad_in | input | NUM_PINS | Pad input levels (asynchronous) |
| pad_out | output | NUM_PINS | Output values toward pads |
| pad_oe | output | NUM_PINS | Output enables toward pads |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds one instance per trigger type, each with a 4-pin port, and sweeps every ordered pair of 4-bit pad values under a varying mask. Each sweep step checks the capture word and the interrupt against values computed arithmetically in the bench:
- An edge detector with the wrong polarity, or a missing level-mode bypass, shows up as wrong capture bits.
- A synchroniser that is one stage short sets capture a cycle early, so the capture word is already nonzero at the intermediate sample taken after the second edge.

Further directed steps cover the remaining corners:
- Partial write-one-to-clear must leave the bits written as 0 intact.
- A clear landing in the same cycle as a fresh edge must keep the bit; a design with the wrong priority would drop it.
- Mask bits above the pin count must read back as zero.
- Data readback mixes output-register and pad bits by direction; a design that returned only one source would fail this check.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    TRIG_RISE  = 2'd0,
    TRIG_FALL  = 2'd1,
    TRIG_BOTH  = 2'd2,
    TRIG_LEVEL = 2'd3
  } trig_e;

  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] A_DIR  = 2'd1;
  localparam logic [ADDR_W-1:0] A_MASK = 2'd2;
  localparam logic [ADDR_W-1:0] A_CAP  = 2'd3;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      always_comb stage_d = d;
    end else begin : g_next
      always_comb stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pio_capture.sv
module pio_capture
  import pio_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter trig_e       TRIG  = TRIG_RISE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl,
  input  logic [WIDTH-1:0] clr,
  output logic [WIDTH-1:0] cap
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] edge_ev;
  logic [WIDTH-1:0] cap_q, cap_d;

  if (TRIG == TRIG_RISE) begin : g_rise
    always_comb edge_ev = lvl & ~prev_q;
  end else if (TRIG == TRIG_FALL) begin : g_fall
    always_comb edge_ev = ~lvl & prev_q;
  end else if (TRIG == TRIG_BOTH) begin : g_both
    always_comb edge_ev = lvl ^ prev_q;
  end else begin : g_level
    always_comb edge_ev = '0;
  end

  // a fresh edge wins over a clear in the same cycle
  always_comb cap_d = (cap_q & ~clr) | edge_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      cap_q  <= '0;
    end else begin
      prev_q <= lvl;
      cap_q  <= cap_d;
    end
  end

  assign cap = cap_q;

  // R8: bits that were set and not cleared stay set
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(cap_q) & ~$past(clr)) & ~cap_q) == '0));

  // R9: every detected edge is present in the capture word next cycle
  p_no_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cap_q & $past(edge_ev)) == $past(edge_ev)));
endmodule

// File: rtl/pio_edge_port.sv
module pio_edge_port
  import pio_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned BUS_W    = 32,
  parameter trig_e       TRIG     = TRIG_RISE
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic                irq
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [NUM_PINS-1:0] out_q, out_d;
  logic [NUM_PINS-1:0] dir_q, dir_d;
  logic [NUM_PINS-1:0] mask_q, mask_d;
  logic [NUM_PINS-1:0] pin_lvl;
  logic [NUM_PINS-1:0] cap;
  logic [NUM_PINS-1:0] cap_clr;
  logic [NUM_PINS-1:0] data_view;
  logic [NUM_PINS-1:0] wr_bits;
  logic                wr_data, wr_dir, wr_mask, wr_cap;
  logic [BUS_W-1:0]    rd_mux;

  pio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pin_lvl)
  );

  pio_capture #(.WIDTH(NUM_PINS), .TRIG(TRIG)) u_capture (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (pin_lvl),
    .clr   (cap_clr),
    .cap   (cap)
  );

  // write decode
  always_comb begin
    wr_bits = bus_wdata[NUM_PINS-1:0];
    wr_data = bus_wr && (bus_addr == A_DATA);
    wr_dir  = bus_wr && (bus_addr == A_DIR);
    wr_mask = bus_wr && (bus_addr == A_MASK);
    wr_cap  = bus_wr && (bus_addr == A_CAP);
    cap_clr = wr_cap ? wr_bits : '0;
  end

  // next state with explicit enables
  always_comb begin
    out_d  = out_q;
    dir_d  = dir_q;
    mask_d = mask_q;
    if (wr_data) out_d  = wr_bits;
    if (wr_dir)  dir_d  = wr_bits;
    if (wr_mask) mask_d = wr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      mask_q <= '0;
    end else begin
      out_q  <= out_d;
      dir_q  <= dir_d;
      mask_q <= mask_d;
    end
  end

  always_comb data_view = (dir_q & out_q) | (~dir_q & pin_lvl);

  // read path, zero-extended above the pin count
  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      A_DATA:  rd_mux[NUM_PINS-1:0] = data_view;
      A_DIR:   rd_mux[NUM_PINS-1:0] = dir_q;
      A_MASK:  rd_mux[NUM_PINS-1:0] = mask_q;
      default: rd_mux[NUM_PINS-1:0] = cap;
    endcase
    bus_rdata = bus_rd ? rd_mux : '0;
  end

  if (TRIG == TRIG_LEVEL) begin : g_irq_level
    always_comb irq = |(data_view & mask_q);
  end else begin : g_irq_edge
    always_comb irq = |(cap & mask_q);
  end

  assign pad_out = out_q;
  assign pad_oe  = dir_q;

  // R2: a direction write reaches the output enables one edge later
  p_oe_follows_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DIR) |=> (pad_oe == $past(bus_wdata[NUM_PINS-1:0])));

  // R10: no interrupt can be raised with every pin masked
  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0));

  // R12: while in reset the port drives nothing and requests nothing
  always_comb begin
    if (!rst_n) begin
      a_reset_quiet_r12: assert (pad_oe == '0 && irq == 1'b0);
    end
  end
endmodule

// File: tb/pio_edge_port_bench.sv
module pio_edge_port_bench;
  import pio_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NP         = 4;
  localparam int NI         = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_rd, bus_wr;
  logic [1:0]    bus_addr;
  logic [31:0]   bus_wdata;
  logic [NP-1:0] pad_in;

  logic [31:0]   rdata [NI];
  logic [NP-1:0] pout  [NI];
  logic [NP-1:0] poe   [NI];
  logic          irq   [NI];
  logic [31:0]   rdv   [NI];

  int nchk = 0;
  int nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar k = 0; k < NI; k++) begin : g_dut
    pio_edge_port #(.NUM_PINS(NP), .BUS_W(32), .TRIG(trig_e'(k))) u_pio_edge_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (rdata[k]),
      .pad_in    (pad_in),
      .pad_out   (pout[k]),
      .pad_oe    (poe[k]),
      .irq       (irq[k])
    );
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [1:0] a);
    bus_rd = 1'b1; bus_addr = a;
    #1;
    for (int k = 0; k < NI; k++) rdv[k] = rdata[k];
    bus_rd = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  function automatic logic [3:0] exp_cap(input int k, input logic [3:0] p, input logic [3:0] v);
    case (k)
      0:       return v & ~p;
      1:       return p & ~v;
      2:       return p ^ v;
      default: return 4'h0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [3:0] m, e;
    rst_n = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    // R12: reset state
    for (int a = 0; a < 4; a++) begin
      bus_read(2'(a));
      for (int k = 0; k < NI; k++) check("R12 reg after reset", rdv[k], 32'h0);
    end
    for (int k = 0; k < NI; k++) begin
      check("R12 irq after reset", {31'b0, irq[k]}, 32'h0);
      check("R12 oe after reset", {28'b0, poe[k]}, 32'h0);
    end
    // R1: read strobe low gives zero
    bus_write(2'd2, 32'h0000_0005);
    bus_addr = 2'd2; #1;
    check("R1 rdata without strobe", rdata[0], 32'h0);
    // R1: bits above pin count read zero
    bus_write(2'd2, 32'hFFFF_FFFF);
    bus_read(2'd2);
    for (int k = 0; k < NI; k++) check("R1 mask upper bits zero", rdv[k], 32'h0000_000F);
    bus_write(2'd2, 32'h0);

    // R2 / R3: direction, output drive and mixed readback
    bus_write(2'd1, 32'h0000_0003);
    bus_write(2'd0, 32'hFFFF_FFF6);
    pad_in = 4'b1001;
    wait_cyc(3);
    for (int k = 0; k < NI; k++) begin
      check("R2 pad_oe from direction", {28'b0, poe[k]}, 32'h3);
      check("R2 pad_out from output reg", {28'b0, pout[k]}, 32'h6);
    end
    bus_read(2'd0);
    for (int k = 0; k < NI; k++) check("R3 mixed data readback", rdv[k], 32'h0000_000A);
    bus_write(2'd1, 32'h0);
    bus_read(2'd0);
    for (int k = 0; k < NI; k++) begin
      check("R3 all inputs read pads", rdv[k], 32'h0000_0009);
      check("R3 output reg unchanged", {28'b0, pout[k]}, 32'h6);
    end
    bus_write(2'd0, 32'h0);

    // R4-R8, R10, R11: sweep every ordered pair of pad values
    for (int p = 0; p < 16; p++) begin
      for (int v = 0; v < 16; v++) begin
        pad_in = 4'(p);
        wait_cyc(3);
        bus_write(2'd3, 32'hF);
        m = 4'((p * 5 + v * 3 + 1) & 15);
        bus_write(2'd2, {28'b0, m});
        pad_in = 4'(v);
        wait_cyc(2);
        bus_read(2'd3);
        for (int k = 0; k < NI; k++) check("R4 capture not yet set", rdv[k], 32'h0);
        wait_cyc(1);
        bus_read(2'd3);
        for (int k = 0; k < NI; k++) begin
          e = exp_cap(k, 4'(p), 4'(v));
          case (k)
            0: check("R5 rising capture", rdv[k], {28'b0, e});
            1: check("R6 falling capture", rdv[k], {28'b0, e});
            2: check("R7 both capture", rdv[k], {28'b0, e});
            default: check("R11 level no capture", rdv[k], 32'h0);
          endcase
          if (k < 3) check("R10 edge irq", {31'b0, irq[k]}, {31'b0, |(e & m)});
          else       check("R11 level irq", {31'b0, irq[k]}, {31'b0, |(4'(v) & m)});
        end
      end
    end

    // R8: partial clear
    pad_in = 4'h0;
    wait_cyc(3);
    bus_write(2'd3, 32'hF);
    pad_in = 4'hF;
    wait_cyc(3);
    bus_write(2'd3, 32'h5);
    bus_read(2'd3);
    check("R8 rising partial clear", rdv[0], 32'hA);
    check("R8 both partial clear", rdv[2], 32'hA);
    wait_cyc(2);
    bus_read(2'd3);
    check("R8 rising bits hold", rdv[0], 32'hA);

    // R9: edge coincides with clear
    pad_in = 4'h0;
    wait_cyc(3);
    bus_write(2'd3, 32'hF);
    pad_in = 4'h1;
    wait_cyc(3);
    pad_in = 4'h0;
    wait_cyc(3);
    pad_in = 4'h1;
    wait_cyc(2);
    bus_write(2'd3, 32'h1);
    bus_read(2'd3);
    check("R9 rising edge beats clear", rdv[0], 32'h1);
    check("R9 both edge beats clear", rdv[2], 32'h1);
    bus_write(2'd3, 32'h1);
    bus_read(2'd3);
    check("R9 plain clear afterwards", rdv[0], 32'h0);

    summary();
    $finish;
  end
endmodule